// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines (30 by default) and gates them through a software-writable enable mask. It produces a single interrupt request wire and an 8-bit vector toward a processor core. When exactly one enabled line is high, the vector names that line. When two or more are high, the vector takes one fixed shared value, and the interrupt handler reads the status registers to decide which source to service first. No priority encoder sits in the hardware.

Software reaches the block through a simple 32-bit register port. One access is offered per cycle, with a size code. The read data and an error flag come back registered, one cycle after the access. The port exposes the enable mask, the raw line levels, the masked lines and two plain status words: a non-maskable-event word and a debug word. The request and vector outputs are registered and change together, one clock after a line change or a mask update takes effect.

Top module: `vect_irq_ctrl`

## Requirements
- R1: The raw-line register at byte offset 0x04 reads back the current level of every input line, with line i in bit i. Bits at and above the line count read as 0.
- R2: The enable mask at offset 0x00 is a 32-bit read/write word. It changes only on a word write to offset 0x00.
- R3: The masked register at offset 0x08 reads as the raw line levels ANDed bitwise with the enable mask.
- R4: When exactly one masked line i is high, irq_req is 1 and irq_vec is 0x31 + i, one clock after the change.
- R5: When two or more masked lines are high, irq_req is 1 and irq_vec is the shared value 0x30.
- R6: When no masked line is high, irq_req is 0 and irq_vec is 0.
- R7: bus_size encodes 0 = byte, 1 = halfword, 2 = word. A byte or halfword read returns 0, and a byte or halfword write changes no register.
- R8: An access to an offset that is not a multiple of 4, or that is 0x14 or above, sets bus_err for exactly the one response cycle of that access. A read of such an offset returns 0.
- R9: Reset clears the mask, both status words, irq_req and irq_vec to 0.
- R10: Writes to offsets 0x04 and 0x08 are ignored. Those values come only from the lines and the mask.
- R11: The non-maskable-event status at offset 0x0C and the debug status at offset 0x10 are 32-bit read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 30 | Level-sensitive request lines, synchronous to clk |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after the access |
| bus_err | output | 1 | Bad-offset flag, registered, one cycle after the access |
| irq_req | output | 1 | Interrupt request toward the core |
| irq_vec | output | 8 | Interrupt vector toward the core |

## Verification
A corrupted mask bit shows up at the ports within two clocks of a line change: an enabled source fails to raise irq_req, or a single source reports the shared vector 0x30. It also shows up on the very next read of offset 0x00 or 0x08. A miscounted "more than one active" decision shows as a specific line vector where 0x30 is due, or the reverse, one clock after the second line rises. A wrong decode of size or offset appears in the next response cycle, as nonzero read data for a narrow access, a missing or lingering bus_err, or a changed word on the following read-back.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   localparam int OFS_ENABLE = 'h00;
   localparam int OFS_RAW    = 'h04;
   localparam int OFS_MASKED = 'h08;
   localparam int OFS_NMI    = 'h0C;
   localparam int OFS_DEBUG  = 'h10;
   localparam int WINDOW     = 'h14;
   localparam int DATA_W     = 32;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_pkg::*;
#(
   parameter int NUM_LINES = 30,
   parameter int ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 wr,
   input  logic [1:0]           size,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_LINES-1:0] lines,
   output logic [DATA_W-1:0]    rdata,
   output logic                 err,
   output logic [NUM_LINES-1:0] masked
);
   localparam int NREG = WINDOW / 4;

   generate
      if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
         $error("irq_regfile: NUM_LINES must be 1..32");
      end
      if ((1 << ADDR_W) < WINDOW) begin : g_bad_addr
         $error("irq_regfile: ADDR_W too narrow for register window");
      end
   endgenerate

   logic [DATA_W-1:0] enable_q, nmi_q, dbg_q;
   logic [DATA_W-1:0] raw_word, masked_word;
   logic              is_word, in_range;
   logic [NREG-1:0]   hit;

   assign raw_word    = DATA_W'(lines);
   assign masked_word = raw_word & enable_q;
   assign masked      = masked_word[NUM_LINES-1:0];
   assign is_word     = (acc_size_e'(size) == SZ_WORD);
   assign in_range    = (addr[1:0] == 2'b00) && (int'(addr) < WINDOW);

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_hit
         assign hit[g] = in_range && (int'(addr) == g * 4);
      end
   endgenerate

   logic wr_en, wr_nmi, wr_dbg;
   assign wr_en  = sel && wr && is_word && hit[OFS_ENABLE/4];
   assign wr_nmi = sel && wr && is_word && hit[OFS_NMI/4];
   assign wr_dbg = sel && wr && is_word && hit[OFS_DEBUG/4];

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit[OFS_ENABLE/4]) rd_mux = enable_q;
      if (hit[OFS_RAW/4])    rd_mux = raw_word;
      if (hit[OFS_MASKED/4]) rd_mux = masked_word;
      if (hit[OFS_NMI/4])    rd_mux = nmi_q;
      if (hit[OFS_DEBUG/4])  rd_mux = dbg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         nmi_q    <= '0;
         dbg_q    <= '0;
         rdata    <= '0;
         err      <= 1'b0;
      end else begin
         if (wr_en)  enable_q <= wdata;
         if (wr_nmi) nmi_q    <= wdata;
         if (wr_dbg) dbg_q    <= wdata;
         rdata <= (sel && !wr && is_word) ? rd_mux : '0;
         err   <= sel && !in_range;
      end
   end

   // R2
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && wr && is_word && addr == '0) |=> $stable(enable_q));
   // R8
   err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rdata == '0));
   // R7
   narrow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && !is_word) |=> (rdata == '0));
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
   parameter int NUM_LINES  = 30,
   parameter int VEC_W      = 8,
   parameter int SHARED_VEC = 'h30,
   parameter int BASE_VEC   = 'h31
) (
   input  logic [NUM_LINES-1:0] masked,
   output logic                 req_d,
   output logic [VEC_W-1:0]     vec_d
);
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   generate
      if (BASE_VEC + NUM_LINES - 1 >= (1 << VEC_W)) begin : g_bad_vec
         $error("irq_vec_enc: vector range exceeds VEC_W");
      end
      if (SHARED_VEC >= (1 << VEC_W)) begin : g_bad_shared
         $error("irq_vec_enc: shared vector exceeds VEC_W");
      end
   endgenerate

   logic             any, multi;
   logic [IDX_W-1:0] idx;

   assign any = |masked;

   generate
      if (NUM_LINES == 1) begin : g_single
         assign multi = 1'b0;
      end else begin : g_multi
         assign multi = |(masked & (masked - NUM_LINES'(1)));
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--)
         if (masked[i]) idx = IDX_W'(i);
   end

   always_comb begin
      req_d = any;
      if (!any)       vec_d = '0;
      else if (multi) vec_d = VEC_W'(SHARED_VEC);
      else            vec_d = VEC_W'(BASE_VEC + int'(idx));
   end
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_LINES  = 30,
   parameter int ADDR_W     = 5,
   parameter int VEC_W      = 8,
   parameter int SHARED_VEC = 'h30,
   parameter int BASE_VEC   = 'h31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_size,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 bus_err,
   output logic                 irq_req,
   output logic [VEC_W-1:0]     irq_vec
);
   logic [NUM_LINES-1:0] masked;
   logic                 req_d;
   logic [VEC_W-1:0]     vec_d;

   irq_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (bus_sel),
      .wr     (bus_wr),
      .size   (bus_size),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .lines  (irq_lines),
      .rdata  (bus_rdata),
      .err    (bus_err),
      .masked (masked)
   );

   irq_vec_enc #(
      .NUM_LINES (NUM_LINES),
      .VEC_W     (VEC_W),
      .SHARED_VEC(SHARED_VEC),
      .BASE_VEC  (BASE_VEC)
   ) u_enc (
      .masked (masked),
      .req_d  (req_d),
      .vec_d  (vec_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_vec <= '0;
      end else begin
         irq_req <= req_d;
         irq_vec <= vec_d;
      end
   end

   // R6
   idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == '0));
   // R5
   shared_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(masked) > 1) |=> (irq_req && irq_vec == VEC_W'(SHARED_VEC)));
   // R4
   single_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec != VEC_W'(SHARED_VEC)) |->
         (int'(irq_vec) >= BASE_VEC && int'(irq_vec) < BASE_VEC + NUM_LINES));
   // R4
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(masked) |=> (irq_req && irq_vec != VEC_W'(SHARED_VEC)));
endmodule

// File: tb/sim_vect_irq_ctrl.sv
module sim_vect_irq_ctrl;
   localparam int N = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_lines = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_size = 2'd2;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err, irq_req;
   logic [7:0]  irq_vec;

   int compared = 0, mismatched = 0;
   logic [31:0] m_enable = '0;

   logic [32:0] exp_q[$];
   string       tag_q[$];
   logic        rsp_due = 1'b0;

   always #10 clk = ~clk;

   vect_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   always @(posedge clk) rsp_due <= bus_sel && rst_n;

   // monitor: pops one expected response per access
   always @(negedge clk) begin
      if (rsp_due && exp_q.size() > 0) begin
         logic [32:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         compared++;
         if ({bus_err, bus_rdata} !== e) begin
            mismatched++;
            $display("FAIL %s: err/rdata actual %0b/%08h expected %0b/%08h",
                     t, bus_err, bus_rdata, e[32], e[31:0]);
         end
      end
   end

   task automatic access(input logic wr, input logic [1:0] sz, input logic [4:0] a,
                         input logic [31:0] wd, input logic [31:0] ed,
                         input logic ee, input string t);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
      exp_q.push_back({ee, ed});
      tag_q.push_back(t);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   function automatic logic [7:0] model_vec(input logic [N-1:0] m);
      int cnt = 0, first = 0;
      for (int i = N - 1; i >= 0; i--) if (m[i]) begin cnt++; first = i; end
      if (cnt == 0) return 8'h00;
      if (cnt > 1) return 8'h30;
      return 8'(8'h31 + first);
   endfunction

   task automatic chk_out(input string t);
      logic [7:0] ev;
      logic [N-1:0] m;
      @(negedge clk); @(negedge clk);
      m  = irq_lines & m_enable[N-1:0];
      ev = model_vec(m);
      compared++;
      if (irq_req !== (m != '0) || irq_vec !== ev) begin
         mismatched++;
         $display("FAIL %s: req/vec actual %0b/%02h expected %0b/%02h",
                  t, irq_req, irq_vec, (m != '0), ev);
      end
   endtask

   task automatic set_enable(input logic [31:0] v);
      access(1'b1, 2'd2, 5'h00, v, 32'h0, 1'b0, "R2 write");
      m_enable = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk_out("R9 outputs after reset");
      access(0, 2'd2, 5'h00, 0, 32'h0, 0, "R9 enable after reset");
      access(0, 2'd2, 5'h0C, 0, 32'h0, 0, "R9 nmi after reset");
      access(0, 2'd2, 5'h10, 0, 32'h0, 0, "R9 debug after reset");
      // R2
      set_enable(32'hFFFF_FFFF);
      access(0, 2'd2, 5'h00, 0, 32'hFFFF_FFFF, 0, "R2 enable readback");
      // R4 single lines
      irq_lines = 30'h1;
      chk_out("R4 line 0");
      irq_lines = 30'h2000_0000;
      chk_out("R4 line 29");
      irq_lines = 30'h0000_0400;
      chk_out("R4 line 10");
      // R5 multiple
      irq_lines = 30'h0000_0401;
      chk_out("R5 two lines");
      irq_lines = 30'h3FFF_FFFF;
      chk_out("R5 all lines");
      // R1 raw readback, upper bits zero
      access(0, 2'd2, 5'h04, 0, 32'h3FFF_FFFF, 0, "R1 raw all high");
      // R3 masked read and masking effect
      irq_lines = 30'h0000_0C00;
      set_enable(32'h0000_0800);
      chk_out("R3 masked single after enable change");
      access(0, 2'd2, 5'h08, 0, 32'h0000_0800, 0, "R3 masked read");
      access(0, 2'd2, 5'h04, 0, 32'h0000_0C00, 0, "R1 raw read");
      // R6 none
      set_enable(32'h0000_0000);
      chk_out("R6 all masked");
      irq_lines = '0;
      set_enable(32'hFFFF_FFFF);
      chk_out("R6 no lines");
      // R7 narrow accesses
      access(0, 2'd0, 5'h00, 0, 32'h0, 0, "R7 byte read");
      access(0, 2'd1, 5'h00, 0, 32'h0, 0, "R7 half read");
      access(1, 2'd0, 5'h00, 32'h0000_0001, 32'h0, 0, "R7 byte write");
      access(1, 2'd1, 5'h0C, 32'h0000_1234, 32'h0, 0, "R7 half write");
      access(0, 2'd2, 5'h00, 0, 32'hFFFF_FFFF, 0, "R7 enable unchanged");
      access(0, 2'd2, 5'h0C, 0, 32'h0, 0, "R7 nmi unchanged");
      // R8 bad offsets
      access(0, 2'd2, 5'h14, 0, 32'h0, 1, "R8 read 0x14");
      access(0, 2'd2, 5'h00, 0, 32'hFFFF_FFFF, 0, "R8 err clears");
      access(1, 2'd2, 5'h1C, 32'hDEAD_BEEF, 32'h0, 1, "R8 write 0x1C");
      access(0, 2'd2, 5'h02, 0, 32'h0, 1, "R8 unaligned");
      access(0, 2'd2, 5'h10, 0, 32'h0, 0, "R8 debug untouched");
      // R10 derived registers ignore writes
      irq_lines = 30'h0000_0020;
      access(1, 2'd2, 5'h04, 32'hFFFF_FFFF, 32'h0, 0, "R10 write raw");
      access(1, 2'd2, 5'h08, 32'h0, 32'h0, 0, "R10 write masked");
      access(0, 2'd2, 5'h04, 0, 32'h0000_0020, 0, "R10 raw unchanged");
      access(0, 2'd2, 5'h08, 0, 32'h0000_0020, 0, "R10 masked unchanged");
      chk_out("R10 outputs unchanged");
      // R11 status words
      access(1, 2'd2, 5'h0C, 32'hA5A5_0001, 32'h0, 0, "R11 nmi write");
      access(1, 2'd2, 5'h10, 32'h5A5A_8000, 32'h0, 0, "R11 debug write");
      access(0, 2'd2, 5'h0C, 0, 32'hA5A5_0001, 0, "R11 nmi read");
      access(0, 2'd2, 5'h10, 0, 32'h5A5A_8000, 0, "R11 debug read");
      // R9 reset mid-run
      irq_lines = 30'h0000_0003;
      chk_out("R5 before reset");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      compared++;
      if (irq_req !== 1'b0 || irq_vec !== 8'h00) begin
         mismatched++;
         $display("FAIL R9 outputs in reset: actual %0b/%02h expected 0/00", irq_req, irq_vec);
      end
      rst_n = 1'b1;
      m_enable = '0;
      access(0, 2'd2, 5'h00, 0, 32'h0, 0, "R9 enable cleared");
      access(0, 2'd2, 5'h0C, 0, 32'h0, 0, "R9 nmi cleared");
      chk_out("R9 no request after reset");
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule